// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a ring of 16-byte transmit descriptors held in host memory. Software sets the ring base address and then rings a doorbell. The block reads each descriptor in turn and hands every frame that software has marked as ready to a downstream frame engine. When the engine reports that the frame is done, the block writes the descriptor's control word back with the ownership bit cleared, which returns the descriptor to software. It then raises a per-descriptor transmit-OK or transmit-error pulse.

The block has three interfaces. A synchronous single-word memory port carries the request/response traffic. A small register write port holds the base address and the doorbell. A valid/done pair connects to the frame engine. The scan ends at the first descriptor that the hardware does not own. A doorbell that arrives while a scan is running is remembered and causes one more pass, so a descriptor handed over late is not stranded. The ring index returns to slot zero on a soft reset and whenever transmit enable rises.

The state machine (`fetch_state_e`) has these states and transitions:

- `S_IDLE` moves to `S_RD_CTRL` on a pending doorbell.
- `S_RD_CTRL` moves to `S_WT_CTRL`.
- `S_WT_CTRL` waits for the response. It then goes to:
  - `S_RD_LO` if the descriptor is owned;
  - `S_RD_CTRL` if it is not owned and a doorbell is pending (rescan);
  - `S_IDLE` otherwise (stop).
- `S_RD_LO` moves to `S_WT_LO`, then to `S_RD_HI` on the response.
- `S_RD_HI` moves to `S_WT_HI`. On the response it goes to `S_XMIT` for a complete single-segment frame, or straight to `S_WBACK` otherwise.
- `S_XMIT` moves to `S_WBACK` on `frm_done`.
- `S_WBACK` moves to `S_RD_CTRL` with the index advanced.
- From any state, transmit enable low or soft reset forces `S_IDLE`.

Top module: `txring_fetch`

## Requirements
- R1: A register write with `reg_addr`=1 and bit 6 of `reg_wdata` set starts a scan. Other bits of that write do nothing, and a write without bit 6 starts nothing.
- R2: A write with `reg_addr`=0 sets the ring base, with its low 8 bits forced to zero. Descriptor i sits at base+16*i. Its control word is at +0, its buffer address low word at +8 and its high word at +12. The word at +4 is never accessed.
- R3: For an owned descriptor (control bit 31 = 1) with both first-segment (bit 29) and last-segment (bit 28) set, `frm_valid` rises. `frm_len` = control[15:0] and `frm_addr` = {high word, low word}, both held stable until `frm_done`.
- R4: After `frm_done`, the control word is written back to +0 with only bit 31 cleared. `ev_tx_ok` pulses in the same cycle as that write.
- R5: An owned descriptor that lacks bit 29 or bit 28 is never presented to the frame engine. It is written back with bit 31 cleared and `ev_tx_err` pulses in that write cycle. The two events never pulse together.
- R6: The scan stops at the first descriptor whose bit 31 is 0. That descriptor is not written.
- R7: After a descriptor with end-of-ring (bit 30) set, the next fetch is at slot 0. Otherwise it is at the next slot, modulo 2^IDX_W.
- R8: A doorbell that arrives during a scan, including in the cycle the scan stops, causes a further scan from the slot where the scan stopped.
- R9: `soft_rst` and a rising edge of `tx_en` set the ring index to 0. While `tx_en` is low, no memory request is made and doorbells are discarded.
- R10: Memory reads are single word-aligned requests. The block waits for `mem_rvalid`, however many cycles that takes. After reset no request, frame or event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable level |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = ring base, 1 = doorbell |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| frm_valid | output | 1 | Frame handed to the engine |
| frm_len | output | LEN_W | Frame length in bytes |
| frm_addr | output | 64 | Frame buffer address |
| frm_done | input | 1 | Engine finished the frame |
| ev_tx_ok | output | 1 | Descriptor completed cleanly |
| ev_tx_err | output | 1 | Descriptor completed with a segment error |

## Verification
Two functions can fall in the same cycle: the scan stopping on an unowned descriptor, and a new doorbell write. The bench waits for the read of the unowned control word. In the cycle its response returns, the bench flips that descriptor to owned in memory and issues the doorbell. The result is judged by counting the reads of that control word (exactly two are expected) and by the scoreboard receiving the frame and write-back that only the rescan can produce. A doorbell during frame transmission is checked the same way.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int OWN_B       = 31;
    localparam int EOR_B       = 30;
    localparam int FS_B        = 29;
    localparam int LS_B        = 28;
    localparam int DB_NORMAL_B = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CTRL, S_WT_CTRL, S_RD_LO, S_WT_LO,
        S_RD_HI, S_WT_HI, S_XMIT, S_WBACK
    } fetch_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              consume,
    output logic [ADDR_W-1:0] base_q,
    output logic              pend_q
);
    import txr_pkg::*;

    logic door_hit;
    logic unused_bits;

    assign door_hit    = reg_wr && reg_addr && reg_wdata[DB_NORMAL_B];
    assign unused_bits = ^{reg_wdata[ALIGN_BITS-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (reg_wr && !reg_addr)
                base_q <= {reg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            if (soft_rst || !tx_en)
                pend_q <= 1'b0;
            else
                pend_q <= (pend_q && !consume) || door_hit;
        end
    end

    // R9: doorbells are discarded while the transmitter is disabled
    a_r9_door_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !pend_q);
endmodule

// File: rtl/txr_index.sv
module txr_index #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                idx_q <= '0;
        else if (clr)              idx_q <= '0;
        else if (adv && wrap)      idx_q <= '0;
        else if (adv)              idx_q <= idx_q + 1'b1;
    end

    a_r9_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> idx_q == '0);
    a_r7_ring_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        adv && wrap && !clr |=> idx_q == '0);
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 10,
    parameter int LEN_W      = 16,
    parameter int ALIGN_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              frm_valid,
    output logic [LEN_W-1:0]  frm_len,
    output logic [63:0]       frm_addr,
    input  logic              frm_done,
    output logic              ev_tx_ok,
    output logic              ev_tx_err
);
    import txr_pkg::*;

    localparam int DESC_SH = 4;
    localparam logic [3:0] OFF_CTRL = 4'd0;
    localparam logic [3:0] OFF_LO   = 4'd8;
    localparam logic [3:0] OFF_HI   = 4'd12;

    fetch_state_e state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pend_q, consume, tx_en_q, idx_clr;
    logic [31:0]       ctrl_q, lo_q, hi_q;
    logic [3:0]        off;
    logic              good;

    assign idx_clr = soft_rst || (tx_en && !tx_en_q);
    assign good    = ctrl_q[FS_B] && ctrl_q[LS_B];

    txr_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .consume(consume), .base_q(base_q), .pend_q(pend_q));

    txr_index #(.IDX_W(IDX_W)) u_index (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr),
        .adv(state_q == S_WBACK), .wrap(ctrl_q[EOR_B]), .idx_q(idx_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tx_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tx_en_q <= tx_en;
        end
    end

    // descriptor word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (mem_rvalid) begin
            if (state_q == S_WT_CTRL) ctrl_q <= mem_rdata;
            if (state_q == S_WT_LO)   lo_q   <= mem_rdata;
            if (state_q == S_WT_HI)   hi_q   <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            S_IDLE:    if (pend_q) begin state_d = S_RD_CTRL; consume = 1'b1; end
            S_RD_CTRL: state_d = S_WT_CTRL;
            S_WT_CTRL: if (mem_rvalid) begin
                           if (mem_rdata[OWN_B]) state_d = S_RD_LO;
                           else if (pend_q) begin state_d = S_RD_CTRL; consume = 1'b1; end
                           else state_d = S_IDLE;
                       end
            S_RD_LO:   state_d = S_WT_LO;
            S_WT_LO:   if (mem_rvalid) state_d = S_RD_HI;
            S_RD_HI:   state_d = S_WT_HI;
            S_WT_HI:   if (mem_rvalid) state_d = good ? S_XMIT : S_WBACK;
            S_XMIT:    if (frm_done) state_d = S_WBACK;
            S_WBACK:   state_d = S_RD_CTRL;
            default:   state_d = S_IDLE;
        endcase
        if (!tx_en || soft_rst) begin
            state_d = S_IDLE;
            consume = 1'b0;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        off       = OFF_CTRL;
        frm_valid = 1'b0;
        ev_tx_ok  = 1'b0;
        ev_tx_err = 1'b0;
        unique case (state_q)
            S_RD_CTRL: mem_req = 1'b1;
            S_RD_LO:   begin mem_req = 1'b1; off = OFF_LO; end
            S_RD_HI:   begin mem_req = 1'b1; off = OFF_HI; end
            S_XMIT:    frm_valid = 1'b1;
            S_WBACK:   begin
                           mem_req   = 1'b1;
                           mem_we    = 1'b1;
                           ev_tx_ok  = good;
                           ev_tx_err = !good;
                       end
            default:   ;
        endcase
    end

    assign mem_addr  = base_q + ADDR_W'({idx_q, {DESC_SH{1'b0}}}) + ADDR_W'(off);
    assign mem_wdata = {1'b0, ctrl_q[OWN_B-1:0]};
    assign frm_len   = ctrl_q[LEN_W-1:0];
    assign frm_addr  = {hi_q, lo_q};

    a_r4_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_B]);
    a_r4_event_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_ok || ev_tx_err |-> mem_req && mem_we);
    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_tx_ok, ev_tx_err}));
    a_r3_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_done && tx_en && !soft_rst |=>
        frm_valid && $stable(frm_len) && $stable(frm_addr));
    a_r10_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !mem_req);
endmodule

// File: tb/txring_fetch_test.sv
`timescale 1ns/1ps
module txring_fetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en, soft_rst, reg_wr, reg_addr;
    logic [31:0] reg_wdata;
    logic        mem_req, mem_we, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        frm_valid, frm_done, ev_tx_ok, ev_tx_err;
    logic [15:0] frm_len;
    logic [63:0] frm_addr;

    always #10 clk = ~clk;

    txring_fetch uut (.*);

    localparam int BASE = 32'h100;
    localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000,
                            FS = 32'h2000_0000, LS = 32'h1000_0000;

    logic [31:0] mem [0:255];
    int lat = 1;
    int rd_cnt = 0;
    logic [31:0] rd_a;

    // memory model: read response after lat cycles
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_we) begin
            rd_a   <= mem_addr;
            rd_cnt <= lat;
        end else if (rd_cnt != 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[rd_a[9:2]];
            end
        end
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // frame engine model: done three cycles after valid
    int fcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            frm_done <= 1'b0; fcnt <= 0;
        end else if (frm_done) begin
            frm_done <= 1'b0; fcnt <= 0;
        end else if (frm_valid) begin
            fcnt <= fcnt + 1;
            if (fcnt == 2) frm_done <= 1'b1;
        end
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // scoreboard queues
    logic [63:0] qf_addr[$];
    logic [15:0] qf_len[$];
    logic [31:0] qw_addr[$];
    logic [31:0] qw_data[$];
    bit          qw_ok[$];
    int rd_total = 0, watch_hits = 0;
    logic [31:0] watch = '1;
    bit fseen = 0;

    always @(negedge clk) if (rst_n) begin
        if (mem_req && !mem_we) begin
            rd_total++;
            if (mem_addr == watch) watch_hits++;
        end
        if (frm_valid && !fseen) begin
            fseen = 1;
            if (qf_addr.size() == 0) chk(0, "R5", "unexpected frame", frm_addr, 0);
            else begin
                logic [63:0] ea;
                logic [15:0] el;
                ea = qf_addr.pop_front();
                el = qf_len.pop_front();
                chk(frm_addr == ea, "R3", "frame address", frm_addr, ea);
                chk(frm_len == el, "R3", "frame length", frm_len, el);
            end
        end else if (!frm_valid) fseen = 0;
        if (mem_req && mem_we) begin
            if (qw_addr.size() == 0) chk(0, "R6", "unexpected write-back", mem_addr, 0);
            else begin
                logic [31:0] wa, wd;
                bit ok;
                wa = qw_addr.pop_front();
                wd = qw_data.pop_front();
                ok = qw_ok.pop_front();
                chk(mem_addr == wa, "R2", "write-back address", mem_addr, wa);
                chk(mem_wdata == wd, "R4", "write-back data", mem_wdata, wd);
                chk(ev_tx_ok == ok && ev_tx_err == !ok, "R5", "event ok/err",
                    {ev_tx_ok, ev_tx_err}, {ok, !ok});
            end
        end
    end

    function automatic int dw(input int i);
        return BASE / 4 + i * 4;
    endfunction

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_desc(input int i, input logic [31:0] c,
                            input logic [31:0] lo, input logic [31:0] hi);
        mem[dw(i)] = c; mem[dw(i) + 1] = 32'hDEAD_0000 + i;
        mem[dw(i) + 2] = lo; mem[dw(i) + 3] = hi;
    endtask

    // driver side of the scoreboard
    task automatic expect_desc(input int i);
        logic [31:0] c;
        c = mem[dw(i)];
        if (c[29] && c[28]) begin
            qf_addr.push_back({mem[dw(i) + 3], mem[dw(i) + 2]});
            qf_len.push_back(c[15:0]);
        end
        qw_addr.push_back(BASE + 16 * i);
        qw_data.push_back(c & ~OWN);
        qw_ok.push_back(c[29] && c[28]);
    endtask

    task automatic drain(input string rq);
        int t = 0;
        while ((qf_addr.size() + qw_addr.size()) != 0 && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(t < 3000, rq, "scoreboard drained", qw_addr.size(), 0);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tx_en = 0; soft_rst = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 0, "R10", "reset mem_req", mem_req, 0);
        chk(frm_valid == 0, "R10", "reset frm_valid", frm_valid, 0);
        chk({ev_tx_ok, ev_tx_err} == 0, "R10", "reset events", {ev_tx_ok, ev_tx_err}, 0);

        // R9: doorbell while disabled is ignored
        set_desc(0, OWN | FS | LS | 60, 32'h1000, 32'h2);
        reg_write(1, 32'h40);
        repeat (20) @(negedge clk);
        chk(rd_total == 0, "R9", "reads while disabled", rd_total, 0);

        // R1/R2: base alignment, doorbell without bit 6
        tx_en = 1'b1;
        reg_write(0, 32'h0000_01AB);
        reg_write(1, 32'h0000_00BF & ~32'h40);
        repeat (20) @(negedge clk);
        chk(rd_total == 0, "R1", "reads after non-start write", rd_total, 0);

        // R1/R3/R4/R6: two frames then stop
        lat = 2;
        set_desc(1, OWN | FS | LS | 100, 32'h2000, 32'h0);
        set_desc(2, FS | LS | 5, 32'h9, 32'h9);
        expect_desc(0); expect_desc(1);
        reg_write(1, 32'hFFFF_FFFF);
        drain("R1");
        chk(mem[dw(2)] == (FS | LS | 5), "R6", "unowned untouched", mem[dw(2)], FS | LS | 5);
        chk(mem[dw(0)] == 32'h3000_003C, "R4", "released control", mem[dw(0)], 32'h3000_003C);
        chk(mem[dw(0) + 1] == 32'hDEAD_0000, "R2", "word +4 untouched", mem[dw(0) + 1], 32'hDEAD_0000);

        // R7: end-of-ring wrap
        lat = 1;
        set_desc(2, OWN | FS | LS | 200, 32'h3000, 32'h0);
        set_desc(3, OWN | EOR | FS | LS | 300, 32'h4000, 32'h1);
        set_desc(0, OWN | FS | LS | 400, 32'h5000, 32'h7);
        expect_desc(2); expect_desc(3); expect_desc(0);
        reg_write(1, 32'h40);
        drain("R7");
        chk(mem[dw(3)] == (EOR | FS | LS | 300), "R7", "eor kept", mem[dw(3)], EOR | FS | LS | 300);

        // R5: segment errors
        lat = 3;
        set_desc(1, OWN | FS | 50, 32'h6000, 32'h0);
        set_desc(2, OWN | LS | 70, 32'h7000, 32'h0);
        expect_desc(1); expect_desc(2);
        reg_write(1, 32'h40);
        drain("R5");

        // R8: doorbell during a frame, descriptor handed over late
        lat = 1;
        set_desc(3, OWN | EOR | FS | LS | 120, 32'h8000, 32'h0);
        expect_desc(3);
        watch = BASE; watch_hits = 0;
        reg_write(1, 32'h40);
        while (!frm_valid) @(negedge clk);
        reg_write(1, 32'h40);
        while (!(mem_req && !mem_we && mem_addr == BASE)) @(negedge clk);
        @(negedge clk);
        while (!mem_rvalid) @(negedge clk);
        set_desc(0, OWN | FS | LS | 77, 32'hA000, 32'h3);
        expect_desc(0);
        drain("R8");
        chk(watch_hits == 2, "R8", "rescan reads (busy doorbell)", watch_hits, 2);

        // R8: doorbell in the same cycle the scan stops
        lat = 2;
        watch = BASE + 16; watch_hits = 0;
        reg_write(1, 32'h40);
        while (!(mem_req && !mem_we && mem_addr == BASE + 16)) @(negedge clk);
        @(negedge clk);
        while (!mem_rvalid) @(negedge clk);
        set_desc(1, OWN | FS | LS | 90, 32'hB000, 32'h0);
        expect_desc(1);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h40;
        @(negedge clk);
        reg_wr = 1'b0;
        drain("R8");
        chk(watch_hits == 2, "R8", "rescan reads (stop-cycle doorbell)", watch_hits, 2);

        // R9: soft reset returns to slot 0
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        set_desc(0, OWN | FS | LS | 500, 32'hC000, 32'h0);
        expect_desc(0);
        reg_write(1, 32'h40);
        drain("R9");

        // R9: transmit enable rising edge returns to slot 0
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        set_desc(0, OWN | FS | LS | 600, 32'hD000, 32'h5);
        expect_desc(0);
        reg_write(1, 32'h40);
        drain("R9");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule